// File: doc/BRIEF.md
# Three-Phase Active Power Gain and Offset Calibrator

This block sits between the per-phase average active power filters and the energy accumulators of a polyphase metering datapath. Each arriving sample carries a phase tag (A, B or C) and a signed 28-bit power value. The block first scales the value by a fractional correction around unity, taken from that phase's signed 24-bit gain register. It then adds that phase's signed 24-bit offset register, counted in power-input LSBs. The calibrated sample leaves one clock later, together with its phase tag and a valid strobe.

The six calibration registers are held in a small register bank. The bank is written and read as 32-bit words. A 24-bit register is stored as written. On read-back it is sign-extended to the 28-bit datapath width, and the four top bits of the word are zero. The datapath holds no state between samples apart from the output register. A register write therefore affects the first sample presented after the write edge.

The block contains no multi-state controller. It is one registered pipeline stage. An enumerated phase code selects the calibration pair for each sample.

Top module: `power_calib`

## Requirements
- R1: After reset `cal_valid` is 0 and all six calibration registers read back as 0.
- R2: With gain and offset of a phase at 0, the output power equals the input power one clock after the sample, and `cal_phase` repeats the sample's phase code.
- R3: The scaled value is floor(P·(2^23 + G) / 2^23). P is the input power and G is the gain register read as a signed 24-bit number. The scaling is exact before rounding.
- R4: Gain code 0xC00000 halves the input and gain code 0x400000 multiplies it by 1.5. Both round toward negative infinity, so −1001 halved gives −501.
- R5: The scaled value is clipped to the 28-bit signed range [−2^27, 2^27−1] before the offset is added.
- R6: The offset register, read as a signed 24-bit number, is added to the scaled value in input-LSB units. The sum is clipped to the same 28-bit signed range.
- R7: A read returns bits 31:28 as zero and bits 27:0 as the 24-bit register value sign-extended to 28 bits. Write-data bits 31:24 are discarded.
- R8: `cfg_addr` bit 2 selects the register kind (0 = gain, 1 = offset) and bits 1:0 select the phase (0 = A, 1 = B, 2 = C). A write with phase field 3 changes no register, and a read with phase field 3 returns 0.
- R9: Each phase uses only its own gain and offset. A write to one phase leaves the outputs of the other phases unchanged.
- R10: A sample presented in the same cycle as a register write is calibrated with the old register value. The next sample uses the new value.
- R11: A sample with phase code 3 produces no output strobe.
- R12: A sample with phase code 0, 1 or 2 raises `cal_valid` for exactly one cycle, one clock later. Without a sample, `cal_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address: bit 2 kind, bits 1:0 phase |
| cfg_wdata | input | 32 | Write data; bits 23:0 are used |
| cfg_rdata | output | 32 | Read-back of the addressed register (combinational) |
| smp_valid | input | 1 | Input sample strobe |
| smp_phase | input | 2 | Phase code of the input sample |
| smp_power | input | 28 | Signed input power |
| cal_valid | output | 1 | Calibrated sample strobe |
| cal_phase | output | 2 | Phase code of the calibrated sample |
| cal_power | output | 28 | Signed calibrated power |

## Verification
The assertions assume that the sample inputs are driven away from the clock edge and are stable across it. They also assume that `cfg_addr` selects a single register for the whole cycle, so that the read-back word is a clean function of stored state. The directed tasks change inputs only on the falling clock edge and drop `smp_valid` between samples. They also cover the unmapped phase code 3, both as a sample tag and as a register address, so that the dropped-strobe and read-back properties are exercised and not left vacuous.

// File: rtl/pwrcal_pkg.sv
package pwrcal_pkg;

    localparam int unsigned PWR_W   = 28;
    localparam int unsigned CAL_W   = 24;
    localparam int unsigned BUS_W   = 32;
    localparam int unsigned N_PHASE = 3;
    localparam int unsigned GAIN_FRAC = 23;
    localparam int unsigned PH_W    = 2;

    typedef enum logic [PH_W-1:0] {
        PH_A    = 2'd0,
        PH_B    = 2'd1,
        PH_C    = 2'd2,
        PH_NONE = 2'd3
    } phase_e;

endpackage

// File: rtl/pwrcal_regbank.sv
module pwrcal_regbank #(
    parameter int unsigned NPH  = 3,
    parameter int unsigned RW   = 24,
    parameter int unsigned DW   = 28,
    parameter int unsigned BW   = 32,
    parameter int unsigned PHW  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [PHW:0]            addr,
    input  logic [BW-1:0]           wdata,
    output logic [BW-1:0]           rdata,
    output logic [NPH-1:0][RW-1:0]  gain_q,
    output logic [NPH-1:0][RW-1:0]  off_q
);

    localparam int unsigned PAD_W = BW - DW;
    localparam int unsigned EXT_W = DW - RW;

    logic            kind_off;
    logic [PHW-1:0]  ph_sel;
    logic [RW-1:0]   rd_raw;
    logic            rd_hit;

    assign kind_off = addr[PHW];
    assign ph_sel   = addr[PHW-1:0];

    for (genvar i = 0; i < NPH; i++) begin : g_phase
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                gain_q[i] <= '0;
            end else if (wr && !kind_off && (ph_sel == PHW'(i))) begin
                gain_q[i] <= wdata[RW-1:0];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                off_q[i] <= '0;
            end else if (wr && kind_off && (ph_sel == PHW'(i))) begin
                off_q[i] <= wdata[RW-1:0];
            end
        end
    end

    always_comb begin
        rd_raw = '0;
        rd_hit = 1'b0;
        for (int i = 0; i < int'(NPH); i++) begin
            if (ph_sel == PHW'(i)) begin
                rd_hit = 1'b1;
                rd_raw = kind_off ? off_q[i] : gain_q[i];
            end
        end
    end

    assign rdata = rd_hit ? {{PAD_W{1'b0}}, {EXT_W{rd_raw[RW-1]}}, rd_raw} : '0;

endmodule

// File: rtl/pwrcal_scaler.sv
module pwrcal_scaler #(
    parameter int unsigned DW   = 28,
    parameter int unsigned RW   = 24,
    parameter int unsigned FRAC = 23
) (
    input  logic signed [DW-1:0] p_in,
    input  logic signed [RW-1:0] gain,
    output logic signed [DW-1:0] p_out
);

    localparam int unsigned FW = FRAC + 2;
    localparam int unsigned PW = DW + FW;
    localparam logic signed [FW-1:0] UNITY = FW'(1) << FRAC;
    localparam logic signed [PW-1:0] MAXV  = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV  = ~MAXV;

    logic signed [FW-1:0] g_ext;
    logic signed [FW-1:0] factor;
    logic signed [PW-1:0] p_wide;
    logic signed [PW-1:0] f_wide;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shifted;

    assign g_ext   = {{(FW-RW){gain[RW-1]}}, gain};
    assign factor  = UNITY + g_ext;
    assign p_wide  = {{FW{p_in[DW-1]}}, p_in};
    assign f_wide  = {{DW{factor[FW-1]}}, factor};
    assign prod    = p_wide * f_wide;
    assign shifted = prod >>> FRAC;

    always_comb begin
        if (shifted > MAXV) begin
            p_out = MAXV[DW-1:0];
        end else if (shifted < MINV) begin
            p_out = MINV[DW-1:0];
        end else begin
            p_out = shifted[DW-1:0];
        end
    end

endmodule

// File: rtl/pwrcal_offset.sv
module pwrcal_offset #(
    parameter int unsigned DW = 28,
    parameter int unsigned RW = 24
) (
    input  logic signed [DW-1:0] p_in,
    input  logic signed [RW-1:0] offset,
    output logic signed [DW-1:0] p_out
);

    localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

    logic signed [DW-1:0] o_ext;
    logic signed [DW:0]   sum;

    assign o_ext = {{(DW-RW){offset[RW-1]}}, offset};
    assign sum   = {p_in[DW-1], p_in} + {o_ext[DW-1], o_ext};

    always_comb begin
        if (sum[DW] != sum[DW-1]) begin
            p_out = sum[DW] ? MINV : MAXV;
        end else begin
            p_out = sum[DW-1:0];
        end
    end

endmodule

// File: rtl/power_calib.sv
module power_calib
    import pwrcal_pkg::*;
#(
    parameter int unsigned DW   = PWR_W,
    parameter int unsigned RW   = CAL_W,
    parameter int unsigned BW   = BUS_W,
    parameter int unsigned NPH  = N_PHASE,
    parameter int unsigned FRAC = GAIN_FRAC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [2:0]      cfg_addr,
    input  logic [31:0]     cfg_wdata,
    output logic [31:0]     cfg_rdata,
    input  logic            smp_valid,
    input  logic [1:0]      smp_phase,
    input  logic [27:0]     smp_power,
    output logic            cal_valid,
    output logic [1:0]      cal_phase,
    output logic [27:0]     cal_power
);

    logic [NPH-1:0][RW-1:0] gain_q;
    logic [NPH-1:0][RW-1:0] off_q;
    phase_e                 cur_ph;
    logic                   ph_ok;
    logic signed [RW-1:0]   cur_gain;
    logic signed [RW-1:0]   cur_off;
    logic signed [DW-1:0]   scaled;
    logic signed [DW-1:0]   corrected;

    pwrcal_regbank #(
        .NPH (NPH),
        .RW  (RW),
        .DW  (DW),
        .BW  (BW),
        .PHW (PH_W)
    ) i_regbank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .gain_q (gain_q),
        .off_q  (off_q)
    );

    assign cur_ph = phase_e'(smp_phase);

    always_comb begin
        ph_ok    = 1'b0;
        cur_gain = '0;
        cur_off  = '0;
        unique case (cur_ph)
            PH_A: begin
                ph_ok    = 1'b1;
                cur_gain = gain_q[0];
                cur_off  = off_q[0];
            end
            PH_B: begin
                ph_ok    = 1'b1;
                cur_gain = gain_q[1];
                cur_off  = off_q[1];
            end
            PH_C: begin
                ph_ok    = 1'b1;
                cur_gain = gain_q[2];
                cur_off  = off_q[2];
            end
            PH_NONE: begin
                ph_ok    = 1'b0;
            end
        endcase
    end

    pwrcal_scaler #(
        .DW   (DW),
        .RW   (RW),
        .FRAC (FRAC)
    ) i_scaler (
        .p_in  (smp_power),
        .gain  (cur_gain),
        .p_out (scaled)
    );

    pwrcal_offset #(
        .DW (DW),
        .RW (RW)
    ) i_offset (
        .p_in   (scaled),
        .offset (cur_off),
        .p_out  (corrected)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_valid <= 1'b0;
            cal_phase <= '0;
            cal_power <= '0;
        end else begin
            cal_valid <= smp_valid && ph_ok;
            if (smp_valid && ph_ok) begin
                cal_phase <= smp_phase;
                cal_power <= corrected;
            end
        end
    end

endmodule

// File: rtl/pwrcal_checker.sv
module pwrcal_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] cfg_rdata,
    input logic        smp_valid,
    input logic [1:0]  smp_phase,
    input logic        cal_valid,
    input logic [1:0]  cal_phase
);

    a_r12_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_phase != 2'd3) |=> cal_valid);

    a_r12_quiet_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !cal_valid);

    a_r11_unmapped_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_phase == 2'd3) |=> !cal_valid);

    a_r2_phase_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_phase != 2'd3) |=> (cal_phase == $past(smp_phase)));

    a_r7_top_nibble_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[31:28] == 4'h0);

    a_r7_sign_extended: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[27:23] == 5'h00) || (cfg_rdata[27:23] == 5'h1f));

endmodule

bind power_calib pwrcal_checker i_pwrcal_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rdata (cfg_rdata),
    .smp_valid (smp_valid),
    .smp_phase (smp_phase),
    .cal_valid (cal_valid),
    .cal_phase (cal_phase)
);

// File: tb/test_power_calib.sv
module test_power_calib;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        smp_valid = 1'b0;
    logic [1:0]  smp_phase = '0;
    logic [27:0] smp_power = '0;
    logic        cal_valid;
    logic [1:0]  cal_phase;
    logic [27:0] cal_power;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    power_calib i_power_calib (
        .clk (clk), .rst_n (rst_n),
        .cfg_wr (cfg_wr), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
        .smp_valid (smp_valid), .smp_phase (smp_phase), .smp_power (smp_power),
        .cal_valid (cal_valid), .cal_phase (cal_phase), .cal_power (cal_power)
    );

    function automatic longint sx24(input logic [23:0] c);
        return c[23] ? longint'(c) - 64'sd16777216 : longint'(c);
    endfunction

    function automatic longint clip28(input longint v);
        if (v > 134217727) return 134217727;
        if (v < -134217728) return -134217728;
        return v;
    endfunction

    function automatic longint ref_cal(input longint p, input logic [23:0] g, input logic [23:0] o);
        longint s;
        s = (p * (64'sd8388608 + sx24(g))) >>> 23;
        s = clip28(s);
        return clip28(s + sx24(o));
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    // drives one sample and returns what appears after the capturing edge
    task automatic send(input logic [1:0] ph, input longint p,
                        output logic v, output logic [1:0] oph, output longint op);
        @(negedge clk);
        smp_valid = 1'b1; smp_phase = ph; smp_power = p[27:0];
        @(negedge clk);
        smp_valid = 1'b0;
        v = cal_valid; oph = cal_phase; op = longint'($signed(cal_power));
    endtask

    task automatic send_chk(input string tag, input logic [1:0] ph, input longint p, input longint exp);
        logic v; logic [1:0] oph; longint op;
        send(ph, p, v, oph, op);
        chk({tag, " valid"}, longint'(v), 1);
        chk({tag, " phase"}, longint'(oph), longint'(ph));
        chk({tag, " power"}, op, exp);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        @(negedge clk);
        chk("R1 cal_valid after reset", longint'(cal_valid), 0);
        for (int k = 0; k < 8; k++) begin
            if (k[1:0] != 2'd3) begin
                cfg_read(3'(k), d);
                chk("R1 register cleared", longint'(d), 0);
            end
        end
    endtask

    task automatic t_identity;
        send_chk("R2 identity A", 2'd0, 123456, 123456);
        send_chk("R2 identity B", 2'd1, -98765, -98765);
        send_chk("R2 identity C max", 2'd2, 134217727, 134217727);
        send_chk("R2 identity C min", 2'd2, -134217728, -134217728);
        @(negedge clk);
        chk("R12 single cycle strobe", longint'(cal_valid), 0);
    endtask

    task automatic t_half_and_more;
        cfg_write(3'd0, 32'h00C00000);
        send_chk("R4 minus half", 2'd0, 1000, 500);
        send_chk("R4 minus half floor", 2'd0, -1001, -501);
        cfg_write(3'd0, 32'h00400000);
        send_chk("R4 plus half", 2'd0, 1000, 1500);
        send_chk("R3 plus half odd", 2'd0, -3, -5);
        cfg_write(3'd0, 32'h00800000);
        send_chk("R3 gain -100pct", 2'd0, 777777, 0);
        cfg_write(3'd0, 32'h00000001);
        send_chk("R3 one lsb gain", 2'd0, 8388608, 8388609);
        cfg_write(3'd0, 32'h0);
    endtask

    task automatic t_gain_clip;
        cfg_write(3'd1, 32'h007FFFFF);
        send_chk("R5 clip high", 2'd1, 134217727, 134217727);
        send_chk("R5 clip low", 2'd1, -134217728, -134217728);
        cfg_write(3'd5, 32'h00FFFFFF);
        send_chk("R5 clip before offset", 2'd1, 100000000, 134217726);
        cfg_write(3'd1, 32'h0);
        cfg_write(3'd5, 32'h0);
    endtask

    task automatic t_offset;
        cfg_write(3'd6, 32'h00000010);
        send_chk("R6 positive offset", 2'd2, 1000, 1016);
        cfg_write(3'd6, 32'h00FFFFF0);
        send_chk("R6 negative offset", 2'd2, 1000, 984);
        cfg_write(3'd6, 32'h00000005);
        send_chk("R6 sum clip high", 2'd2, 134217725, 134217727);
        cfg_write(3'd6, 32'h00800000);
        send_chk("R6 sum clip low", 2'd2, -134000000, -134217728);
        cfg_write(3'd6, 32'h0);
    endtask

    task automatic t_readback;
        logic [31:0] d;
        cfg_write(3'd0, 32'hAB800001);
        cfg_read(3'd0, d);
        chk("R7 negative readback", longint'(d), longint'(32'h0F800001));
        cfg_write(3'd4, 32'hFF123456);
        cfg_read(3'd4, d);
        chk("R7 positive readback", longint'(d), longint'(32'h00123456));
        cfg_write(3'd0, 32'h0);
        cfg_write(3'd4, 32'h0);
    endtask

    task automatic t_addr_map;
        logic [31:0] d;
        cfg_write(3'd3, 32'h00400000);
        cfg_write(3'd7, 32'h00000100);
        cfg_read(3'd3, d);
        chk("R8 gain phase 3 reads zero", longint'(d), 0);
        cfg_read(3'd7, d);
        chk("R8 offset phase 3 reads zero", longint'(d), 0);
        for (int k = 0; k < 3; k++)
            send_chk("R8 unmapped write ignored", 2'(k), 4000, 4000);
        cfg_write(3'd5, 32'h00000007);
        cfg_read(3'd1, d);
        chk("R8 offset write leaves gain", longint'(d), 0);
        cfg_read(3'd5, d);
        chk("R8 offset B stored", longint'(d), 7);
        cfg_write(3'd5, 32'h0);
    endtask

    task automatic t_independence;
        cfg_write(3'd1, 32'h00C00000);
        cfg_write(3'd5, 32'h00000003);
        send_chk("R9 phase B calibrated", 2'd1, 2000, 1003);
        send_chk("R9 phase A untouched", 2'd0, 2000, 2000);
        send_chk("R9 phase C untouched", 2'd2, 2000, 2000);
        cfg_write(3'd1, 32'h0);
        cfg_write(3'd5, 32'h0);
    endtask

    task automatic t_write_timing;
        logic v; logic [1:0] oph; longint op;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 3'd0; cfg_wdata = 32'h00400000;
        smp_valid = 1'b1; smp_phase = 2'd0; smp_power = 28'd1000;
        @(negedge clk);
        cfg_wr = 1'b0; smp_valid = 1'b0;
        chk("R10 same-cycle write uses old gain", longint'($signed(cal_power)), 1000);
        send(2'd0, 1000, v, oph, op);
        chk("R10 next sample uses new gain", op, 1500);
        cfg_write(3'd0, 32'h0);
    endtask

    task automatic t_drop;
        logic v; logic [1:0] oph; longint op;
        send(2'd3, 555, v, oph, op);
        chk("R11 phase 3 no strobe", longint'(v), 0);
        send(2'd2, 555, v, oph, op);
        chk("R12 strobe after valid sample", longint'(v), 1);
    endtask

    task automatic t_random;
        logic [23:0] g [3];
        logic [23:0] o [3];
        logic [23:0] codes [6] = '{24'h000000, 24'h7FFFFF, 24'h800000, 24'hC00000, 24'h400000, 24'h000000};
        for (int r = 0; r < 6; r++) begin
            for (int ph = 0; ph < 3; ph++) begin
                g[ph] = (r < 5) ? codes[(r + ph) % 5] : 24'($urandom);
                o[ph] = (r % 2 == 0) ? 24'($urandom % 512) - 24'd256 : 24'($urandom);
                cfg_write({1'b0, 2'(ph)}, {8'h00, g[ph]});
                cfg_write({1'b1, 2'(ph)}, {8'h00, o[ph]});
            end
            for (int n = 0; n < 20; n++) begin
                int ph = n % 3;
                logic [27:0] pw = 28'($urandom);
                send_chk("R3 R6 random", 2'(ph), longint'($signed(pw)),
                         ref_cal(longint'($signed(pw)), g[ph], o[ph]));
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_identity();
        t_half_and_more();
        t_gain_clip();
        t_offset();
        t_readback();
        t_addr_map();
        t_independence();
        t_write_timing();
        t_drop();
        t_random();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R12 watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule